// File: doc/BRIEF.md
# Mailbox Semaphore Lock Controller

This block guards one shared request/response mailbox that sits behind a command interface. A requester issues a send command to claim the mailbox. If the mailbox is free, the block grants it and returns a completion code whose high nibble is 0x4 and whose low nibble is a 4-bit transaction ID that the block generates itself. A later get command must present that same ID to collect the response. The lock is given back only when the checksum of that read has gone out in full. An abort before that point leaves the lock in place, so the get can be tried again.

So that a forgotten lock cannot block the mailbox for ever, a watchdog adds up the cycles in which the sampled bus is low while the lock is held. When that total reaches a parameterised cycle count, the lock drops on its own. A disable input freezes this watchdog completely. Serial framing and checksum arithmetic sit outside the block. The block receives decoded strobes and drives registered completion codes, an abort-checksum flag and the lock status.

Top module: `mbx_lock_ctrl`

## Requirements
- R1: After reset the lock is free, no completion code or abort is driven, and the first ID granted is 0.
- R2: A send command while the lock is free produces, on the next cycle, cc_valid_o high with cc_o = {4'h4, ID}, and lock_held_o goes high.
- R3: Each grant uses the previous granted ID plus one, modulo 16, so the IDs run 0,1,...,15,0. All 16 values are used.
- R4: A send command while the lock is held returns cc_o = 8'h80 (busy). It changes neither the lock nor the held ID.
- R5: A get command with the lock free, or with an ID that differs from the held one, returns cc_o = 8'h81 (failed). It leaves the lock state unchanged.
- R6: A get command with the matching ID while rsp_ready_i is low pulses abort_fcs_o for one cycle, drives no completion code and keeps the lock.
- R7: A get command with the matching ID while rsp_ready_i is high returns cc_o = {4'h4, ID} and starts the read phase.
- R8: fcs_done_i during the read phase releases the lock on the next cycle. fcs_done_i outside a read phase has no effect.
- R9: fcs_abort_i during the read phase ends the read but keeps the lock, and a repeated get with the same ID succeeds.
- R10: Once the bus-low cycles counted since the last grant reach TMO_CYCLES, the lock is cleared on that cycle's edge. The low cycles do not have to be consecutive, and a later get fails with 8'h81.
- R11: While tmo_disable_i is high, bus-low cycles are not counted and the watchdog never clears the lock.
- R12: When send and get arrive in the same cycle, only the get is handled and the send is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_i | input | 1 | Decoded send command strobe |
| get_i | input | 1 | Decoded get command strobe |
| get_id_i | input | 4 | ID presented with a get command |
| bus_low_i | input | 1 | Bus sampled low this cycle |
| fcs_done_i | input | 1 | Last bit of the read checksum has gone out |
| fcs_abort_i | input | 1 | Read aborted before the last checksum bit |
| rsp_ready_i | input | 1 | Response data is available |
| tmo_disable_i | input | 1 | Freezes the auto-release watchdog |
| cc_valid_o | output | 1 | Completion code valid this cycle |
| cc_o | output | 8 | Completion code |
| abort_fcs_o | output | 1 | Get answered with an abort checksum |
| lock_held_o | output | 1 | Mailbox lock is held |

## Verification
Random cycles mix sends and gets. Most gets carry the held ID and the rest carry a wrong one, so the matching path and the mismatch path are told apart in the same run. Toggling rsp_ready_i separates the abort-checksum answer from a real read. Sparse fcs_done_i and fcs_abort_i pulses, some of them outside a read, separate a true release from a retry and from a stray strobe. Directed cases run the ID through its wrap from 15 to 0, reach the watchdog limit with bus-low cycles that have gaps between them, hold the watchdog frozen with the disable input, and present send and get together.

// File: rtl/mbx_lock_pkg.sv
package mbx_lock_pkg;
   localparam int unsigned CC_W = 8;
   localparam logic [3:0] CC_PASS_HI = 4'h4;
   localparam logic [CC_W-1:0] CC_BUSY = 8'h80;
   localparam logic [CC_W-1:0] CC_FAIL = 8'h81;

   typedef enum logic [1:0] {
      ST_FREE = 2'd0,
      ST_HELD = 2'd1,
      ST_READ = 2'd2
   } lock_state_e;
endpackage

// File: rtl/mbx_txn_id_gen.sv
module mbx_txn_id_gen #(
   parameter int unsigned ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_i,
   output logic [ID_W-1:0] id_o
);
   logic [ID_W-1:0] nxt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_q <= '0;
      end else if (adv_i) begin
         nxt_q <= nxt_q + 1'b1;
      end
   end

   assign id_o = nxt_q;
endmodule

// File: rtl/mbx_low_timer.sv
module mbx_low_timer #(
   parameter int unsigned LIMIT  = 200000,
   parameter bit          ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   input  logic low_i,
   input  logic dis_i,
   output logic expire_o
);
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("mbx_low_timer: LIMIT must be at least 2");
   end

   if (ENABLE) begin : g_timer
      logic [CNT_W-1:0] cnt_q;
      logic             tick;

      assign tick = run_i && low_i && !dis_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clear_i) begin
            cnt_q <= '0;
         end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end

      assign expire_o = tick && (cnt_q == LAST);
   end else begin : g_no_timer
      assign expire_o = 1'b0;
   end
endmodule

// File: rtl/mbx_lock_fsm.sv
module mbx_lock_fsm
   import mbx_lock_pkg::*;
#(
   parameter int unsigned ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            send_i,
   input  logic            get_i,
   input  logic [ID_W-1:0] get_id_i,
   input  logic            rsp_ready_i,
   input  logic            fcs_done_i,
   input  logic            fcs_abort_i,
   input  logic            expire_i,
   input  logic [ID_W-1:0] new_id_i,
   output logic            acquire_o,
   output logic            locked_o,
   output logic            cc_valid_o,
   output logic [CC_W-1:0] cc_o,
   output logic            abort_fcs_o
);
   lock_state_e     st_q, st_d;
   logic [ID_W-1:0] held_q;
   logic            id_match, get_ok, get_wait, get_bad, send_busy;
   logic            cv_d, ab_d;
   logic [CC_W-1:0] cc_d;

   assign locked_o  = (st_q != ST_FREE);
   assign id_match  = get_i && locked_o && (get_id_i == held_q);
   assign get_ok    = id_match && rsp_ready_i;
   assign get_wait  = id_match && !rsp_ready_i;
   assign get_bad   = get_i && !id_match;
   assign acquire_o = send_i && !get_i && !locked_o;
   assign send_busy = send_i && !get_i && locked_o;

   always_comb begin
      st_d = st_q;
      if (expire_i) begin
         st_d = ST_FREE;
      end else if (st_q == ST_READ && fcs_done_i) begin
         st_d = ST_FREE;
      end else if (st_q == ST_READ && fcs_abort_i) begin
         st_d = ST_HELD;
      end else if (get_ok) begin
         st_d = ST_READ;
      end else if (acquire_o) begin
         st_d = ST_HELD;
      end
   end

   always_comb begin
      cv_d = 1'b0;
      ab_d = 1'b0;
      cc_d = '0;
      if (get_ok) begin
         cv_d = 1'b1;
         cc_d = {CC_PASS_HI, held_q};
      end else if (get_wait) begin
         ab_d = 1'b1;
      end else if (get_bad) begin
         cv_d = 1'b1;
         cc_d = CC_FAIL;
      end else if (acquire_o) begin
         cv_d = 1'b1;
         cc_d = {CC_PASS_HI, new_id_i};
      end else if (send_busy) begin
         cv_d = 1'b1;
         cc_d = CC_BUSY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_FREE;
         held_q      <= '0;
         cc_valid_o  <= 1'b0;
         cc_o        <= '0;
         abort_fcs_o <= 1'b0;
      end else begin
         st_q        <= st_d;
         cc_valid_o  <= cv_d;
         cc_o        <= cc_d;
         abort_fcs_o <= ab_d;
         if (acquire_o) begin
            held_q <= new_id_i;
         end
      end
   end
endmodule

// File: rtl/mbx_lock_ctrl.sv
module mbx_lock_ctrl
   import mbx_lock_pkg::*;
#(
   parameter int unsigned ID_W        = 4,
   parameter int unsigned TMO_CYCLES  = 200000,
   parameter bit          HAS_TIMEOUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            send_i,
   input  logic            get_i,
   input  logic [ID_W-1:0] get_id_i,
   input  logic            bus_low_i,
   input  logic            fcs_done_i,
   input  logic            fcs_abort_i,
   input  logic            rsp_ready_i,
   input  logic            tmo_disable_i,
   output logic            cc_valid_o,
   output logic [CC_W-1:0] cc_o,
   output logic            abort_fcs_o,
   output logic            lock_held_o
);
   if (ID_W != 4) begin : g_bad_id_w
      $error("mbx_lock_ctrl: the ID must fill the low nibble of the code");
   end

   logic            acquire, locked, expire;
   logic [ID_W-1:0] next_id;

   mbx_txn_id_gen #(.ID_W(ID_W)) u_idgen (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (acquire),
      .id_o  (next_id)
   );

   mbx_low_timer #(.LIMIT(TMO_CYCLES), .ENABLE(HAS_TIMEOUT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (acquire),
      .run_i    (locked),
      .low_i    (bus_low_i),
      .dis_i    (tmo_disable_i),
      .expire_o (expire)
   );

   mbx_lock_fsm #(.ID_W(ID_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .send_i      (send_i),
      .get_i       (get_i),
      .get_id_i    (get_id_i),
      .rsp_ready_i (rsp_ready_i),
      .fcs_done_i  (fcs_done_i),
      .fcs_abort_i (fcs_abort_i),
      .expire_i    (expire),
      .new_id_i    (next_id),
      .acquire_o   (acquire),
      .locked_o    (locked),
      .cc_valid_o  (cc_valid_o),
      .cc_o        (cc_o),
      .abort_fcs_o (abort_fcs_o)
   );

   assign lock_held_o = locked;
endmodule

// File: rtl/mbx_lock_chk.sv
module mbx_lock_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       send_i,
   input logic       get_i,
   input logic       lock_held_o,
   input logic       cc_valid_o,
   input logic [7:0] cc_o,
   input logic       abort_fcs_o
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!lock_held_o && !cc_valid_o && !abort_fcs_o));

   // R2
   grant_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (send_i && !get_i && !lock_held_o) |=> (cc_valid_o && cc_o[7:4] == 4'h4 && lock_held_o));

   // R4
   busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (send_i && !get_i && lock_held_o) |=> (cc_valid_o && cc_o == 8'h80));

   // R5
   free_get_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (get_i && !lock_held_o) |=> (cc_valid_o && cc_o == 8'h81 && !lock_held_o));

   // R6
   abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cc_valid_o, abort_fcs_o}));

   // R12
   get_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (send_i && get_i && !lock_held_o) |=> !lock_held_o);
endmodule

bind mbx_lock_ctrl mbx_lock_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .send_i      (send_i),
   .get_i       (get_i),
   .lock_held_o (lock_held_o),
   .cc_valid_o  (cc_valid_o),
   .cc_o        (cc_o),
   .abort_fcs_o (abort_fcs_o)
);

// File: tb/mbx_lock_ctrl_tb.sv
`timescale 1ns/1ps
module mbx_lock_ctrl_tb;
   localparam int TMO = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       send_i = 0, get_i = 0, bus_low_i = 0, fcs_done_i = 0;
   logic       fcs_abort_i = 0, rsp_ready_i = 0, tmo_disable_i = 0;
   logic [3:0] get_id_i = '0;
   logic       cc_valid_o, abort_fcs_o, lock_held_o;
   logic [7:0] cc_o;

   int total = 0;
   int bad = 0;

   // bench model state
   int         m_state = 0;   // 0 free, 1 held, 2 read
   logic [3:0] m_id = '0;
   logic [3:0] m_nid = '0;
   int         m_cnt = 0;
   logic       e_cv = 0, e_ab = 0;
   logic [7:0] e_cc = '0;
   string      tag = "R1";

   always #2.5 clk = ~clk;

   mbx_lock_ctrl #(.TMO_CYCLES(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .send_i(send_i), .get_i(get_i),
      .get_id_i(get_id_i), .bus_low_i(bus_low_i), .fcs_done_i(fcs_done_i),
      .fcs_abort_i(fcs_abort_i), .rsp_ready_i(rsp_ready_i),
      .tmo_disable_i(tmo_disable_i), .cc_valid_o(cc_valid_o), .cc_o(cc_o),
      .abort_fcs_o(abort_fcs_o), .lock_held_o(lock_held_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // model of the requirements, applied to the inputs present at the edge
   task automatic model();
      bit locked, match, expire, acq;
      int ns;
      locked = (m_state != 0);
      match  = get_i && locked && (get_id_i == m_id);
      expire = locked && bus_low_i && !tmo_disable_i && (m_cnt == TMO - 1);
      acq    = send_i && !get_i && !locked;
      e_cv = 0; e_ab = 0; e_cc = 8'h00;
      if (match && rsp_ready_i) begin e_cv = 1; e_cc = {4'h4, m_id}; tag = "R7"; end
      else if (match) begin e_ab = 1; tag = "R6"; end
      else if (get_i) begin e_cv = 1; e_cc = 8'h81; tag = "R5"; end
      else if (acq) begin e_cv = 1; e_cc = {4'h4, m_nid}; tag = "R2"; end
      else if (send_i) begin e_cv = 1; e_cc = 8'h80; tag = "R4"; end
      else tag = "R8";
      ns = m_state;
      if (expire) ns = 0;
      else if (m_state == 2 && fcs_done_i) ns = 0;
      else if (m_state == 2 && fcs_abort_i) ns = 1;
      else if (match && rsp_ready_i) ns = 2;
      else if (acq) ns = 1;
      if (acq) begin m_cnt = 0; m_id = m_nid; m_nid = m_nid + 1; end
      else if (locked && bus_low_i && !tmo_disable_i) m_cnt = (m_cnt == TMO - 1) ? 0 : m_cnt + 1;
      if (expire) tag = "R10";
      m_state = ns;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      model();
      chk(cc_valid_o == e_cv, {tag, " cc_valid"}, cc_valid_o, e_cv);
      if (e_cv) chk(cc_o == e_cc, {tag, " code"}, cc_o, e_cc);
      chk(abort_fcs_o == e_ab, {tag, " abort"}, abort_fcs_o, e_ab);
      chk(lock_held_o == (m_state != 0), {tag, " lock"}, lock_held_o, m_state != 0);
   endtask

   task automatic idle();
      send_i = 0; get_i = 0; fcs_done_i = 0; fcs_abort_i = 0; bus_low_i = 0;
   endtask

   task automatic do_send();
      idle(); send_i = 1; step(); idle();
   endtask

   task automatic do_get(input logic [3:0] id, input logic rdy);
      idle(); get_i = 1; get_id_i = id; rsp_ready_i = rdy; step(); idle();
   endtask

   initial begin
      #(5 * 150000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(!lock_held_o && !cc_valid_o && !abort_fcs_o, "R1 reset outputs", lock_held_o, 0);
      rst_n = 1;
      idle(); step();

      // R1/R2: first grant carries ID 0
      do_send();
      chk(cc_o == 8'h40, "R1 first id", cc_o, 8'h40);
      // R4: busy, lock and ID kept
      do_send();
      chk(cc_o == 8'h80, "R4 busy", cc_o, 8'h80);
      // R5: wrong ID
      do_get(4'h9, 1'b1);
      // R6: not ready
      do_get(4'h0, 1'b0);
      // R7 then R9 abort and retry
      do_get(4'h0, 1'b1);
      idle(); fcs_abort_i = 1; step(); idle();
      chk(lock_held_o == 1, "R9 kept after abort", lock_held_o, 1);
      do_get(4'h0, 1'b1);
      chk(cc_o == 8'h40, "R9 retry", cc_o, 8'h40);
      idle(); fcs_done_i = 1; step(); idle();
      chk(lock_held_o == 0, "R8 released", lock_held_o, 0);
      // R8: stray done while free
      idle(); fcs_done_i = 1; step(); idle();

      // R3: wrap through all 16 ids
      for (int i = 0; i < 17; i++) begin
         do_send();
         chk(cc_o == {4'h4, 4'(i + 1)}, "R3 id sequence", cc_o, {4'h4, 4'(i + 1)});
         do_get(4'(i + 1), 1'b1);
         idle(); fcs_done_i = 1; step(); idle();
      end

      // R10: gapped low cycles reach the limit
      do_send();
      for (int i = 0; i < 2 * TMO; i++) begin
         idle(); bus_low_i = (i % 2 == 0); step();
      end
      idle();
      chk(lock_held_o == 0, "R10 timed out", lock_held_o, 0);
      do_get(m_id, 1'b1);
      chk(cc_o == 8'h81, "R10 get after timeout", cc_o, 8'h81);

      // R11: disabled watchdog
      do_send();
      tmo_disable_i = 1;
      for (int i = 0; i < 3 * TMO; i++) begin
         idle(); bus_low_i = 1; step();
      end
      idle();
      chk(lock_held_o == 1, "R11 still held", lock_held_o, 1);
      tmo_disable_i = 0;
      do_get(m_id, 1'b1);
      idle(); fcs_done_i = 1; step(); idle();

      // R12: send and get together while free
      idle(); send_i = 1; get_i = 1; get_id_i = m_nid; step(); idle();
      chk(lock_held_o == 0, "R12 send ignored", lock_held_o, 0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         idle();
         r = int'($urandom_range(0, 99));
         send_i      = (r < 25) || (r > 95);
         get_i       = (r >= 25 && r < 55) || (r > 95);
         get_id_i    = ($urandom_range(0, 9) < 7) ? m_id : 4'($urandom);
         rsp_ready_i = ($urandom_range(0, 3) != 0);
         bus_low_i   = ($urandom_range(0, 2) == 0);
         fcs_done_i  = ($urandom_range(0, 7) == 0);
         fcs_abort_i = ($urandom_range(0, 9) == 0);
         tmo_disable_i = ($urandom_range(0, 19) == 0);
         step();
      end
      idle(); tmo_disable_i = 0;
      step();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule